// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Synchronous SRAM

This block is a small, synthesizable synchronous static RAM whose data phase always trails its command by exactly one clock, for reads and writes alike. Because both directions share that single late-data slot, a write may follow a read (or the reverse) on consecutive cycles with no idle cycle between them. Commands, address, byte enables and chip selects are captured on the rising clock edge. The read path has no output register: the word leaves the array combinationally during the cycle after its command.

A load cycle starts an access at the presented address. Advance cycles then continue a 4-beat burst from an internal counter, in linear or interleaved order. A clock-enable input freezes the whole pipeline for a cycle. A sleep input gates the internal clock and blanks the outputs while keeping the contents. An asynchronous output enable controls the data-out valid flag. The bidirectional data pin is modelled as separate data-in, data-out and drive-enable signals.

Top module: `zbt_ft_sram`

## Requirements
- R1: A load cycle (`ld_n`=0, chip selected, `we_n`=1) on an enabled edge is a read. During the next cycle `dout` carries the stored word at `addr` and `dout_en` is 1, provided `oe_n`=0 and `sleep`=0.
- R2: A load cycle with `we_n`=0 is a write. The word on `din` at the next enabled edge is stored. Bit i of `bw_n` (active low) guards bits [9i+8:9i], and a lane whose enable is 1 keeps its old contents. `dout_en` is 0 during a write's data cycle.
- R3: An enabled edge with `ld_n`=1 during a burst ignores `addr`, `we_n` and the chip selects. It issues the next beat with the burst's direction. The upper address bits stay fixed. For beat n (n = 1, 2, 3, then wrapping to 0, counted from the 2-bit start value s), the two low bits are (s+n) mod 4 when `lbo`=0 and s XOR n when `lbo`=1.
- R4: The chip is selected only when `ce1_n`=0, `ce2_n`=0 and `ce3`=1. A load cycle with any other combination is a deselect: `dout_en` is 0 in the next cycle, any burst ends, and later `ld_n`=1 edges issue nothing until the next selected load.
- R5: An edge with `cen_n`=1 is ignored entirely. No command is taken, no pending write completes, and the outputs hold. A pending write takes `din` at the next enabled edge.
- R6: Reads and writes may alternate on consecutive cycles with no idle cycles. A read issued right after a write to the same address returns the newly written data.
- R7: `oe_n`=1 forces `dout_en` to 0 at once and does not disturb the pipeline.
- R8: `sleep`=1 ignores the clock edge just as `cen_n`=1 does, forces `dout_en` to 0, and the stored contents survive it.
- R9: `bw_n` has no effect on reads: reading a word with every lane enable low leaves it unchanged.
- R10: After reset, `dout_en` is 0 and no burst is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the pipeline state |
| cen_n | input | 1 | Active-low clock enable; high freezes the edge |
| sleep | input | 1 | High gates the internal clock and blanks outputs |
| ce1_n | input | 1 | Active-low chip select |
| ce2_n | input | 1 | Active-low chip select |
| ce3 | input | 1 | Active-high chip select |
| ld_n | input | 1 | Low: load new command; high: advance burst |
| we_n | input | 1 | High: read, low: write (load cycles only) |
| addr | input | ADDR_W | Word address |
| bw_n | input | NBYTES | Active-low per-lane write enables |
| lbo | input | 1 | Burst order: 1 interleaved, 0 linear (static) |
| din | input | NBYTES*BYTE_W | Write data, sampled one enabled edge after the command |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dout | output | NBYTES*BYTE_W | Flow-through read data |
| dout_en | output | 1 | High when `dout` should drive the bus |

## Verification
The assertions assume that `lbo` changes only while no burst advance depends on it, and that `oe_n` and `sleep` change only between clock edges. Under these assumptions, a freeze edge keeps `dout_en` steady whenever those two inputs stay steady. The stimulus changes every input once per cycle, a few nanoseconds after the rising edge. It changes `lbo` only at a load cycle and touches `oe_n` and `sleep` only in single marked cycles. Only addresses that were first written with every lane enabled are read, so no expected word depends on uninitialised array contents.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;

   localparam int ORDER_PIN = 0;
   localparam int ORDER_LIN = 1;
   localparam int ORDER_ILV = 2;
endpackage

// File: rtl/zbt_burst_ctr.sv
module zbt_burst_ctr #(
   parameter int ADDR_W     = 6,
   parameter int BURST_BITS = 2,
   parameter int ORDER_MODE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              load,
   input  logic              stop,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              lbo,
   output logic [ADDR_W-1:0] beat_addr,
   output logic              active
);
   import zbt_pkg::*;

   localparam int HI_W = ADDR_W - BURST_BITS;

   logic [ADDR_W-1:0]     base_q;
   logic [BURST_BITS-1:0] cnt_q;
   logic [BURST_BITS-1:0] cnt_nx;
   logic [BURST_BITS-1:0] lo_lin;
   logic [BURST_BITS-1:0] lo_ilv;
   logic [BURST_BITS-1:0] lo_sel;
   logic                  act_q;

   if (BURST_BITS < 1 || HI_W < 1) begin : g_bad_width
      $error("zbt_burst_ctr: BURST_BITS must be at least 1 and below ADDR_W");
   end

   assign cnt_nx = cnt_q + 1'b1;
   assign lo_lin = base_q[BURST_BITS-1:0] + cnt_nx;
   assign lo_ilv = base_q[BURST_BITS-1:0] ^ cnt_nx;

   if (ORDER_MODE == ORDER_LIN) begin : g_lin
      logic unused_lbo;
      assign unused_lbo = lbo;
      assign lo_sel = lo_lin;
   end else if (ORDER_MODE == ORDER_ILV) begin : g_ilv
      logic unused_lbo;
      assign unused_lbo = lbo;
      assign lo_sel = lo_ilv;
   end else begin : g_pin
      assign lo_sel = lbo ? lo_ilv : lo_lin;
   end

   assign beat_addr = load ? addr_in : {base_q[ADDR_W-1:BURST_BITS], lo_sel};
   assign active    = act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
         act_q  <= 1'b0;
      end else if (tick) begin
         if (load) begin
            base_q <= addr_in;
            cnt_q  <= '0;
            act_q  <= 1'b1;
         end else if (stop) begin
            act_q  <= 1'b0;
         end else if (act_q) begin
            cnt_q  <= cnt_nx;
         end
      end
   end
endmodule

// File: rtl/zbt_cmd_pipe.sv
module zbt_cmd_pipe #(
   parameter int ADDR_W = 6,
   parameter int NBYTES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              ld_n,
   input  logic              sel,
   input  logic              we_n,
   input  logic              burst_act,
   input  logic [ADDR_W-1:0] beat_addr,
   input  logic [NBYTES-1:0] bw_n,
   output zbt_pkg::op_e      ph_op,
   output logic [ADDR_W-1:0] ph_addr,
   output logic [NBYTES-1:0] ph_bw_n
);
   import zbt_pkg::*;

   op_e               op_q;
   op_e               op_d;
   logic              bwr_q;
   logic              bwr_d;
   logic [ADDR_W-1:0] addr_q;
   logic [NBYTES-1:0] bw_q;

   always_comb begin
      op_d  = OP_IDLE;
      bwr_d = bwr_q;
      if (!ld_n) begin
         if (sel) begin
            op_d  = we_n ? OP_READ : OP_WRITE;
            bwr_d = !we_n;
         end
      end else if (burst_act) begin
         op_d = bwr_q ? OP_WRITE : OP_READ;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= OP_IDLE;
         bwr_q  <= 1'b0;
         addr_q <= '0;
         bw_q   <= '1;
      end else if (tick) begin
         op_q   <= op_d;
         bwr_q  <= bwr_d;
         addr_q <= beat_addr;
         bw_q   <= bw_n;
      end
   end

   assign ph_op   = op_q;
   assign ph_addr = addr_q;
   assign ph_bw_n = bw_q;
endmodule

// File: rtl/zbt_byte_array.sv
module zbt_byte_array #(
   parameter int ADDR_W = 6,
   parameter int NBYTES = 2,
   parameter int BYTE_W = 9
) (
   input  logic                     clk,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [NBYTES-1:0]        bw_n,
   input  logic [NBYTES*BYTE_W-1:0] wdata,
   output logic [NBYTES*BYTE_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   if (DEPTH * NBYTES * BYTE_W > 65536) begin : g_too_big
      $error("zbt_byte_array: array exceeds the model size limit");
   end

   for (genvar g = 0; g < NBYTES; g++) begin : g_lane
      logic [BYTE_W-1:0] lane_mem [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en && !bw_n[g]) begin
            lane_mem[addr] <= wdata[g*BYTE_W +: BYTE_W];
         end
      end

      assign rdata[g*BYTE_W +: BYTE_W] = lane_mem[addr];
   end
endmodule

// File: rtl/zbt_ft_sram.sv
module zbt_ft_sram #(
   parameter int ADDR_W     = 6,
   parameter int NBYTES     = 2,
   parameter int BYTE_W     = 9,
   parameter int BURST_BITS = 2,
   parameter int ORDER_MODE = 0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cen_n,
   input  logic                     sleep,
   input  logic                     ce1_n,
   input  logic                     ce2_n,
   input  logic                     ce3,
   input  logic                     ld_n,
   input  logic                     we_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [NBYTES-1:0]        bw_n,
   input  logic                     lbo,
   input  logic [NBYTES*BYTE_W-1:0] din,
   input  logic                     oe_n,
   output logic [NBYTES*BYTE_W-1:0] dout,
   output logic                     dout_en
);
   import zbt_pkg::*;

   if (ADDR_W < 2 || NBYTES < 1 || BYTE_W < 1) begin : g_bad_cfg
      $error("zbt_ft_sram: parameter out of range");
   end
   if (ORDER_MODE < ORDER_PIN || ORDER_MODE > ORDER_ILV) begin : g_bad_order
      $error("zbt_ft_sram: ORDER_MODE must be 0, 1 or 2");
   end

   logic              tick;
   logic              sel;
   logic              burst_act;
   logic [ADDR_W-1:0] beat_addr;
   op_e               ph_op;
   logic [ADDR_W-1:0] ph_addr;
   logic [NBYTES-1:0] ph_bw_n;

   assign tick = !cen_n && !sleep;
   assign sel  = !ce1_n && !ce2_n && ce3;

   zbt_burst_ctr #(
      .ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS), .ORDER_MODE(ORDER_MODE)
   ) u_burst (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .load(!ld_n && sel), .stop(!ld_n && !sel),
      .addr_in(addr), .lbo(lbo),
      .beat_addr(beat_addr), .active(burst_act)
   );

   zbt_cmd_pipe #(
      .ADDR_W(ADDR_W), .NBYTES(NBYTES)
   ) u_pipe (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .ld_n(ld_n), .sel(sel), .we_n(we_n),
      .burst_act(burst_act), .beat_addr(beat_addr), .bw_n(bw_n),
      .ph_op(ph_op), .ph_addr(ph_addr), .ph_bw_n(ph_bw_n)
   );

   zbt_byte_array #(
      .ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)
   ) u_array (
      .clk(clk),
      .wr_en(tick && (ph_op == OP_WRITE)),
      .addr(ph_addr), .bw_n(ph_bw_n),
      .wdata(din), .rdata(dout)
   );

   assign dout_en = (ph_op == OP_READ) && !oe_n && !sleep;
endmodule

// File: rtl/zbt_ft_sram_chk.sv
module zbt_ft_sram_chk (
   input logic clk,
   input logic rst_n,
   input logic cen_n,
   input logic sleep,
   input logic ce1_n,
   input logic ce2_n,
   input logic ce3,
   input logic ld_n,
   input logic we_n,
   input logic oe_n,
   input logic dout_en
);
   logic act;
   logic chosen;
   logic last_desel;

   assign act    = !cen_n && !sleep;
   assign chosen = (ce1_n == 1'b0) && (ce2_n == 1'b0) && (ce3 == 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             last_desel <= 1'b1;
      else if (act && !ld_n)  last_desel <= !chosen;
   end

   // R1
   a_r1_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
      act && !ld_n && chosen && we_n |=> (oe_n || sleep || dout_en));

   // R2
   a_r2_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
      act && !ld_n && chosen && !we_n |=> !dout_en);

   // R4
   a_r4_desel_float: assert property (@(posedge clk) disable iff (!rst_n)
      act && !ld_n && !chosen |=> !dout_en);

   // R4 and R10: no burst continues after a deselect or reset
   a_r4_burst_ended: assert property (@(posedge clk) disable iff (!rst_n)
      act && ld_n && last_desel |=> !dout_en);

   // R5
   a_r5_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !act |=> (!$stable(oe_n) || !$stable(sleep) || $stable(dout_en)));

   // R7
   a_r7_oe_blanks: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !dout_en);

   // R8
   a_r8_sleep_blanks: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !dout_en);
endmodule

bind zbt_ft_sram zbt_ft_sram_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .sleep(sleep),
   .ce1_n(ce1_n), .ce2_n(ce2_n), .ce3(ce3), .ld_n(ld_n),
   .we_n(we_n), .oe_n(oe_n), .dout_en(dout_en)
);

// File: tb/zbt_ft_sram_tb.sv
module zbt_ft_sram_tb;
   localparam int AW = 6;
   localparam int NB = 2;
   localparam int BW = 9;
   localparam int DW = NB * BW;
   localparam logic [2:0] SEL = 3'b001;

   typedef struct {
      logic          en;
      logic [DW-1:0] data;
      int            due;
      string         tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cen_n = 1'b0, sleep = 1'b0;
   logic          ce1_n = 1'b1, ce2_n = 1'b1, ce3 = 1'b0;
   logic          ld_n = 1'b1, we_n = 1'b1, lbo = 1'b0, oe_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [NB-1:0] bw_n = '1;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          dout_en;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   exp_t q[$];
   exp_t last_item;
   logic [DW-1:0] ref_mem [1<<AW];
   logic          pv = 1'b0, pw = 1'b0, ba = 1'b0, bwr = 1'b0;
   logic [AW-1:0] pa = '0, bbase = '0;
   logic [NB-1:0] pbw = '1;
   logic [1:0]    bcnt = '0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   zbt_ft_sram u_dut (
      .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .sleep(sleep),
      .ce1_n(ce1_n), .ce2_n(ce2_n), .ce3(ce3), .ld_n(ld_n), .we_n(we_n),
      .addr(addr), .bw_n(bw_n), .lbo(lbo), .din(din), .oe_n(oe_n),
      .dout(dout), .dout_en(dout_en)
   );

   // driver: applies one cycle of stimulus and queues the expected output
   task automatic step(input logic l, input logic w, input logic [2:0] ce,
                       input logic [AW-1:0] a, input logic [NB-1:0] b,
                       input logic [DW-1:0] d, input logic cn, input logic sl,
                       input string tag);
      exp_t it;
      logic [1:0] lo;
      ld_n = l; we_n = w; {ce1_n, ce2_n, ce3} = ce;
      addr = a; bw_n = b; din = d; cen_n = cn; sleep = sl;
      if (cn || sl) begin
         it = last_item;
      end else begin
         if (pv && pw) begin
            for (int i = 0; i < NB; i++)
               if (!pbw[i]) ref_mem[pa][i*BW +: BW] = d[i*BW +: BW];
         end
         if (!l) begin
            if (ce == SEL) begin
               pv = 1'b1; pw = !w; pa = a; pbw = b;
               ba = 1'b1; bwr = !w; bbase = a; bcnt = 2'd0;
            end else begin
               pv = 1'b0; ba = 1'b0;
            end
         end else if (ba) begin
            bcnt = bcnt + 2'd1;
            lo = lbo ? (bbase[1:0] ^ bcnt) : (bbase[1:0] + bcnt);
            pa = {bbase[AW-1:2], lo};
            pv = 1'b1; pw = bwr; pbw = b;
         end else begin
            pv = 1'b0;
         end
         it.en   = pv && !pw;
         it.data = it.en ? ref_mem[pa] : '0;
      end
      it.due = cyc + 1;
      it.tag = tag;
      last_item = it;
      q.push_back(it);
      @(posedge clk);
      #2;
   endtask

   // monitor: compares queued expectations mid-cycle
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].due == cyc) begin
         exp_t it;
         logic en_exp;
         it = q.pop_front();
         en_exp = it.en && !oe_n && !sleep;
         checks++;
         if (dout_en !== en_exp) begin
            errors++;
            $display("FAIL %s dout_en actual %0b expected %0b (cycle %0d)",
                     it.tag, dout_en, en_exp, cyc);
         end else if (en_exp && dout !== it.data) begin
            errors++;
            $display("FAIL %s dout actual %h expected %h (cycle %0d)",
                     it.tag, dout, it.data, cyc);
         end
      end
   end

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      last_item.en = 1'b0; last_item.data = '0; last_item.due = 0; last_item.tag = "R10";
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      #8;
      checks++;
      if (dout_en !== 1'b0) begin
         errors++;
         $display("FAIL R10 dout_en actual %0b expected 0", dout_en);
      end
      @(posedge clk); #2;

      // R2, R3: linear burst write from 6 -> 6,7,4,5
      step(0, 0, SEL, 6, 2'b00, '0, 0, 0, "R2");
      step(1, 1, 3'b101, 0, 2'b00, 18'h00111, 0, 0, "R3");
      step(1, 0, SEL, 0, 2'b00, 18'h00222, 0, 0, "R3");
      step(1, 0, SEL, 0, 2'b00, 18'h00333, 0, 0, "R3");
      // R1, R3: linear read burst from 5 -> 5,6,7,4, then wrap to 5
      step(0, 1, SEL, 5, 2'b00, 18'h00444, 0, 0, "R1");
      step(1, 0, SEL, 0, 2'b00, '0, 0, 0, "R3");
      step(1, 0, SEL, 0, 2'b00, '0, 0, 0, "R3");
      step(1, 0, SEL, 0, 2'b00, '0, 0, 0, "R3");
      step(1, 0, SEL, 0, 2'b00, '0, 0, 0, "R3");
      // R2, R6: full write, lane-0-only write, immediate read
      step(0, 0, SEL, 20, 2'b00, '0, 0, 0, "R2");
      step(0, 0, SEL, 20, 2'b10, 18'h3FE01, 0, 0, "R2");
      step(0, 1, SEL, 20, 2'b00, 18'h0005A, 0, 0, "R6");
      step(0, 0, SEL, 21, 2'b00, '0, 0, 0, "R6");
      step(0, 1, SEL, 21, 2'b00, 18'h1ABCD, 0, 0, "R6");
      // R9: reads with all lane enables low leave the word intact
      step(0, 1, SEL, 20, 2'b00, '0, 0, 0, "R9");
      step(0, 1, SEL, 20, 2'b00, '0, 0, 0, "R9");
      // R3: interleaved write from 9 -> 9,8,11,10; read from 11 -> 11,10,9,8
      lbo = 1'b1;
      step(0, 0, SEL, 9, 2'b00, '0, 0, 0, "R3");
      step(1, 0, SEL, 0, 2'b00, 18'h0A001, 0, 0, "R3");
      step(1, 0, SEL, 0, 2'b00, 18'h0A002, 0, 0, "R3");
      step(1, 0, SEL, 0, 2'b00, 18'h0A003, 0, 0, "R3");
      step(0, 1, SEL, 11, 2'b00, 18'h0A004, 0, 0, "R3");
      step(1, 1, SEL, 0, 2'b00, '0, 0, 0, "R3");
      step(1, 1, SEL, 0, 2'b00, '0, 0, 0, "R3");
      step(1, 1, SEL, 0, 2'b00, '0, 0, 0, "R3");
      // R4: each deselect combination, and advance after deselect
      step(0, 1, 3'b101, 6, 2'b00, '0, 0, 0, "R4");
      step(1, 1, SEL, 0, 2'b00, '0, 0, 0, "R4");
      step(0, 1, 3'b011, 6, 2'b00, '0, 0, 0, "R4");
      step(0, 1, 3'b000, 6, 2'b00, '0, 0, 0, "R4");
      // R4: burst cut short by a deselect
      step(0, 1, SEL, 6, 2'b00, '0, 0, 0, "R1");
      step(1, 1, SEL, 0, 2'b00, '0, 0, 0, "R3");
      step(0, 1, 3'b101, 0, 2'b00, '0, 0, 0, "R4");
      step(1, 1, SEL, 0, 2'b00, '0, 0, 0, "R4");
      step(1, 1, SEL, 0, 2'b00, '0, 0, 0, "R4");
      // R5: freeze during a read burst (7 interleaved -> 7 then 6)
      step(0, 1, SEL, 7, 2'b00, '0, 0, 0, "R1");
      step(0, 0, 3'b101, 9, 2'b00, '0, 1, 0, "R5");
      step(0, 0, 3'b101, 9, 2'b00, '0, 1, 0, "R5");
      step(1, 1, SEL, 0, 2'b00, '0, 0, 0, "R5");
      // R5: write data taken only at the next enabled edge
      step(0, 0, SEL, 30, 2'b00, '0, 0, 0, "R2");
      step(0, 1, SEL, 0, 2'b00, 18'h3FFFF, 1, 0, "R5");
      step(0, 1, SEL, 30, 2'b00, 18'h12345, 0, 0, "R5");
      step(1, 1, 3'b101, 0, 2'b00, '0, 0, 0, "R5");
      // R7: output enable high during a read data cycle
      step(0, 1, SEL, 9, 2'b00, '0, 0, 0, "R7");
      oe_n = 1'b1;
      step(0, 1, SEL, 9, 2'b00, '0, 0, 0, "R7");
      oe_n = 1'b0;
      step(0, 1, 3'b101, 0, 2'b00, '0, 0, 0, "R7");
      // R8: sleep in a burst, then resume (4 interleaved -> 4, then 5)
      step(0, 1, SEL, 4, 2'b00, '0, 0, 0, "R8");
      step(0, 0, 3'b101, 0, 2'b00, '0, 0, 1, "R8");
      step(0, 0, 3'b101, 0, 2'b00, '0, 0, 1, "R8");
      step(1, 1, SEL, 0, 2'b00, '0, 0, 0, "R8");
      step(0, 1, SEL, 6, 2'b00, '0, 0, 0, "R8");
      step(0, 1, 3'b101, 0, 2'b00, '0, 0, 0, "R4");
      repeat (3) @(posedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule